// File: doc/BRIEF.md
# Three-Slot Asymmetric Decode Steering

This unit sits between an in-order instruction queue and three decoders that do not have the same capability. Each cycle the queue presents its three oldest entries on three input lanes. Each entry carries a micro-op count and a flag that marks it as microcode-sequenced. The unit decides which of those entries enter decode this cycle, and it hands them to slots 0, 1 and 2 in program order. Slot 0 is the only slot that accepts an instruction yielding more than one micro-op, and the only one that accepts a microcoded instruction. Slots 1 and 2 take single-micro-op instructions only, and only when slot 0 is filled in the same cycle. The groups formed therefore look like "big-one-one".

The input is a per-lane valid/ready handshake. Lane i is consumed at a clock edge when `in_valid[i]` and `in_ready[i]` are both high. Acceptance is contiguous from lane 0: `in_ready[i]` for i > 0 rises only when lane i is valid, every older lane is accepted, and the entry is legal for its slot. The queue then advances by the number of accepted lanes. A lane that is not accepted keeps its entry, which moves to lane 0 in a later cycle. While a microcoded instruction is being sequenced, every ready is held low. The registered outputs give, one cycle after a handshake, the slot-valid vector and the total micro-ops emitted in that cycle.

Micro-op counts follow the operand form of the instruction: register-register and load forms give 1, store and read-modify forms give 2, register-memory forms give 2 or 3, and read-modify-write forms give 4. A microcoded instruction keeps slot 0 busy for a cycle count it carries. The permitted range is 2 to 15, and the unit emits 4 micro-ops in each of those cycles.

Top module: `tri_slot_decode_steer`

## Requirements
- R1: When no microcoded instruction is in progress, `in_ready[0]` is high, and a valid lane 0 entry of any kind (1 to 4 micro-ops, or microcoded) is accepted into slot 0.
- R2: Lanes 1 and 2 are accepted only for entries with a micro-op count field of exactly 1 and the microcoded flag low.
- R3: Slots 1 and 2 are never filled unless slot 0 is filled in the same cycle. A microcoded entry in slot 0 closes the group, so nothing else is accepted with it.
- R4: An entry with 2 to 4 micro-ops on lane 1 or lane 2 is not accepted. The group closes before it, and the entry is left to reach slot 0 in a later cycle.
- R5: Acceptance follows program order: lane 2 is accepted only if lane 1 is accepted in the same cycle.
- R6: One clock edge after a handshake, `slot_vld` bit i equals the acceptance of lane i, and `uop_total` equals the sum of the accepted micro-op counts. For a microcoded entry, `uop_total` is 4 and its count field is ignored. The total never exceeds 6.
- R7: A microcoded entry with cycle count N produces N consecutive output cycles of `slot_vld` = 3'b001 and `uop_total` = 4. `in_ready` is 3'b000 for the N-1 cycles that follow its acceptance.
- R8: A microcoded cycle count of 0 or 1 is treated as 2.
- R9: Synchronous reset `rst` (active high) ends any microcoded sequence. After the reset edge `slot_vld` is 3'b000, `uop_total` is 0 and `in_ready[0]` is high.
- R10: A cycle with no accepted lane and no sequence in progress gives `slot_vld` = 3'b000 and `uop_total` = 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 3 | Per-lane entry valid; lane 0 is the oldest |
| in_uops | input | 9 | Per-lane micro-op count, 3 bits per lane, lane i at bits [3i+2:3i] |
| in_cplx | input | 3 | Per-lane microcoded flag |
| in_cyc | input | 12 | Per-lane microcoded cycle count, 4 bits per lane, lane i at bits [4i+3:4i] |
| in_ready | output | 3 | Per-lane accept; a lane is consumed when valid and ready are both high |
| slot_vld | output | 3 | Registered: slots filled in the group formed on the previous edge |
| uop_total | output | 4 | Registered: micro-ops emitted in that cycle |

## Verification
The hardest states to reach are mid-sequence ones: cycles in which the queue still offers valid entries while a microcoded instruction holds slot 0, and a reset that lands partway through a long sequence. The bench sweeps every combination of five entry kinds over the three lanes. Whenever a microcoded entry is accepted, it keeps all three lanes valid for the whole sequence so that the forced-low ready is visible. Separate runs cover cycle counts 0 through 15 and a reset issued a few cycles into a count of 15.

// File: rtl/steer_pkg.sv
package steer_pkg;

  // Lane classification, used by the slot rules.
  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_SINGLE = 2'd1,
    CLS_MULTI  = 2'd2,
    CLS_CPLX   = 2'd3
  } lane_class_e;

  localparam int LANES = 3;

  function automatic lane_class_e classify(input logic vld, input logic cplx,
                                           input logic single);
    if (!vld)        return CLS_NONE;
    else if (cplx)   return CLS_CPLX;
    else if (single) return CLS_SINGLE;
    else             return CLS_MULTI;
  endfunction

endpackage

// File: rtl/steer_slot_rules.sv
module steer_slot_rules
  import steer_pkg::*;
#(
  parameter int UOP_W     = 3,
  parameter int SUM_W     = 4,
  parameter int CPLX_RATE = 4
) (
  input  logic [LANES-1:0]       vld,
  input  logic [LANES*UOP_W-1:0] uops,
  input  logic [LANES-1:0]       cplx,
  input  logic                   busy,
  output logic [LANES-1:0]       grant,
  output logic [SUM_W-1:0]       sum
);

  lane_class_e cls [LANES];
  logic [LANES-1:0] open_after;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [UOP_W-1:0] lane_u;
      assign lane_u = uops[g*UOP_W +: UOP_W];
      assign cls[g] = classify(vld[g], cplx[g], lane_u == UOP_W'(1));
      if (g == 0) begin : g_lead
        // Slot 0 takes any kind of entry.
        assign grant[g]      = vld[g] & ~busy;
        assign open_after[g] = grant[g] & (cls[g] != CLS_CPLX);
      end else begin : g_side
        // Side slots take single-uop entries, in order, behind a filled slot 0.
        assign grant[g]      = open_after[g-1] & (cls[g] == CLS_SINGLE);
        assign open_after[g] = grant[g];
      end
    end
  endgenerate

  always_comb begin
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      if (grant[i]) begin
        if (cls[i] == CLS_CPLX) acc = acc + SUM_W'(CPLX_RATE);
        else                    acc = acc + SUM_W'(uops[i*UOP_W +: UOP_W]);
      end
    end
    sum = acc;
  end

endmodule

// File: rtl/steer_seq_ctr.sv
module steer_seq_ctr #(
  parameter int CYC_W   = 4,
  parameter int MIN_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CYC_W-1:0] start_cyc,
  output logic             busy
);

  logic [CYC_W-1:0] remain;
  logic [CYC_W-1:0] eff_cyc;

  assign eff_cyc = (start_cyc < CYC_W'(MIN_CYC)) ? CYC_W'(MIN_CYC) : start_cyc;
  assign busy    = (remain != '0);

  always_ff @(posedge clk) begin
    if (rst)          remain <= '0;
    else if (start)   remain <= eff_cyc - CYC_W'(1);
    else if (busy)    remain <= remain - CYC_W'(1);
  end

endmodule

// File: rtl/steer_out_reg.sv
module steer_out_reg
  import steer_pkg::*;
#(
  parameter int SUM_W     = 4,
  parameter int CPLX_RATE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic [LANES-1:0] grant,
  input  logic [SUM_W-1:0] sum,
  output logic [LANES-1:0] slot_vld,
  output logic [SUM_W-1:0] uop_total
);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld  <= '0;
      uop_total <= '0;
    end else if (busy) begin
      slot_vld  <= LANES'(1);
      uop_total <= SUM_W'(CPLX_RATE);
    end else begin
      slot_vld  <= grant;
      uop_total <= sum;
    end
  end

endmodule

// File: rtl/tri_slot_decode_steer.sv
module tri_slot_decode_steer
  import steer_pkg::*;
#(
  parameter int UOP_W     = 3,
  parameter int CYC_W     = 4,
  parameter int SUM_W     = 4,
  parameter int CPLX_RATE = 4,
  parameter int MIN_CYC   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       in_valid,
  input  logic [LANES*UOP_W-1:0] in_uops,
  input  logic [LANES-1:0]       in_cplx,
  input  logic [LANES*CYC_W-1:0] in_cyc,
  output logic [LANES-1:0]       in_ready,
  output logic [LANES-1:0]       slot_vld,
  output logic [SUM_W-1:0]       uop_total
);

  logic             busy;
  logic [LANES-1:0] grant;
  logic [SUM_W-1:0] sum;
  logic             cplx_start;

  steer_slot_rules #(
    .UOP_W(UOP_W), .SUM_W(SUM_W), .CPLX_RATE(CPLX_RATE)
  ) u_rules (
    .vld(in_valid), .uops(in_uops), .cplx(in_cplx), .busy(busy),
    .grant(grant), .sum(sum)
  );

  assign cplx_start = grant[0] & in_cplx[0];

  steer_seq_ctr #(
    .CYC_W(CYC_W), .MIN_CYC(MIN_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .start(cplx_start),
    .start_cyc(in_cyc[CYC_W-1:0]), .busy(busy)
  );

  steer_out_reg #(
    .SUM_W(SUM_W), .CPLX_RATE(CPLX_RATE)
  ) u_out (
    .clk(clk), .rst(rst), .busy(busy), .grant(grant), .sum(sum),
    .slot_vld(slot_vld), .uop_total(uop_total)
  );

  assign in_ready = {grant[LANES-1:1], ~busy};

endmodule

// File: rtl/steer_checker.sv
module steer_checker #(
  parameter int UOP_W = 3,
  parameter int SUM_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       in_valid,
  input logic [3*UOP_W-1:0] in_uops,
  input logic [2:0]       in_cplx,
  input logic [2:0]       in_ready,
  input logic [2:0]       slot_vld,
  input logic [SUM_W-1:0] uop_total
);

  assert_side_needs_lead_R3: assert property (@(posedge clk) disable iff (rst)
    (slot_vld[1] | slot_vld[2]) |-> slot_vld[0]);

  assert_in_order_R5: assert property (@(posedge clk) disable iff (rst)
    slot_vld[2] |-> slot_vld[1]);

  assert_side_single_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid[1] & in_ready[1]) |->
      (in_uops[2*UOP_W-1:UOP_W] == UOP_W'(1)) && !in_cplx[1]);

  assert_cplx_closes_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid[0] & in_ready[0] & in_cplx[0]) |-> !in_ready[1] && !in_ready[2]);

  assert_busy_after_cplx_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid[0] & in_ready[0] & in_cplx[0]) |=> (in_ready == 3'b000));

  assert_busy_output_R7: assert property (@(posedge clk) disable iff (rst)
    !in_ready[0] |=> (slot_vld == 3'b001) && (uop_total == SUM_W'(4)));

  assert_total_cap_R6: assert property (@(posedge clk) disable iff (rst)
    uop_total <= SUM_W'(6));

endmodule

bind tri_slot_decode_steer steer_checker #(.UOP_W(UOP_W), .SUM_W(SUM_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops),
  .in_cplx(in_cplx), .in_ready(in_ready), .slot_vld(slot_vld),
  .uop_total(uop_total)
);

// File: tb/test_tri_slot_decode_steer.sv
module test_tri_slot_decode_steer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  in_valid = '0;
  logic [8:0]  in_uops  = '0;
  logic [2:0]  in_cplx  = '0;
  logic [11:0] in_cyc   = '0;
  logic [2:0]  in_ready;
  logic [2:0]  slot_vld;
  logic [3:0]  uop_total;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  tri_slot_decode_steer i_tri_slot_decode_steer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops),
    .in_cplx(in_cplx), .in_cyc(in_cyc), .in_ready(in_ready),
    .slot_vld(slot_vld), .uop_total(uop_total)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int act, input int exp, input string req);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = '0; in_cplx = '0; in_uops = '0; in_cyc = '0;
  endtask

  // kind: 0 invalid, 1 one uop, 2 two uops, 3 four uops, 4 microcoded
  task automatic set_lane(input int lane, input int kind, input int cyc);
    in_valid[lane] = (kind != 0);
    in_cplx[lane]  = (kind == 4);
    in_uops[lane*3 +: 3] = (kind == 1) ? 3'd1 : (kind == 2) ? 3'd2 :
                           (kind == 3) ? 3'd4 : (kind == 4) ? 3'd3 : 3'd0;
    in_cyc[lane*4 +: 4] = 4'(cyc);
  endtask

  function automatic int kuops(input int kind);
    return (kind == 1) ? 1 : (kind == 2) ? 2 : (kind == 3) ? 4 : (kind == 4) ? 4 : 0;
  endfunction

  // Drive one window from idle, check ready, group, and any sequence after it.
  task automatic run_window(input int k0, input int k1, input int k2, input int cyc0);
    bit a0, a1, a2;
    int exp_sum, n;
    set_lane(0, k0, cyc0); set_lane(1, k1, 5); set_lane(2, k2, 7);
    a0 = (k0 != 0);
    a1 = a0 && (k0 != 4) && (k1 == 1);
    a2 = a1 && (k2 == 1);
    exp_sum = (a0 ? kuops(k0) : 0) + (a1 ? 1 : 0) + (a2 ? 1 : 0);
    #1;
    check(int'(in_ready[0]), 1, "R1 lane0 ready");
    check(int'(in_ready[1]), int'(a1), (k1 >= 2) ? "R4 lane1 ready" :
                                       (k0 == 4) ? "R3 lane1 ready" : "R2 lane1 ready");
    check(int'(in_ready[2]), int'(a2), "R5 lane2 ready");
    tick();
    check(int'(slot_vld), int'({a2, a1, a0}), "R6 slot_vld");
    check(int'(uop_total), exp_sum, a0 ? "R6 uop_total" : "R10 idle total");
    if (k0 == 4) begin
      n = (cyc0 < 2) ? 2 : cyc0;
      // Keep the queue full during the sequence (R7).
      set_lane(1, 1, 0); set_lane(2, 1, 0);
      for (int c = 1; c < n; c++) begin
        #1;
        check(int'(in_ready), 0, "R7 ready low");
        tick();
        check(int'(slot_vld), 1, "R7 busy slots");
        check(int'(uop_total), 4, "R7 busy total");
      end
      idle();
      #1;
      check(int'(in_ready[0]), 1, (cyc0 < 2) ? "R8 ready back" : "R7 ready back");
    end else begin
      idle();
    end
    tick();
    check(int'(slot_vld), 0, "R10 idle slots");
    check(int'(uop_total), 0, "R10 idle total");
  endtask

  initial begin
    tick(); tick();
    check(int'(slot_vld), 0, "R9 reset slots");
    check(int'(uop_total), 0, "R9 reset total");
    rst = 1'b0;
    #1;
    check(int'(in_ready[0]), 1, "R9 reset ready");
    tick();

    for (int k0 = 0; k0 < 5; k0++)
      for (int k1 = 0; k1 < 5; k1++)
        for (int k2 = 0; k2 < 5; k2++)
          run_window(k0, k1, k2, 2 + ((k1 * 5 + k2) % 14));

    // All cycle counts, including the clamped ones (R8).
    for (int c = 0; c < 16; c++) run_window(4, 1, 1, c);

    // Reset in the middle of a long sequence (R9).
    set_lane(0, 4, 15);
    tick();
    set_lane(0, 1, 0);
    tick(); tick();
    #1;
    check(int'(in_ready[0]), 0, "R7 mid sequence");
    rst = 1'b1;
    tick();
    rst = 1'b0;
    idle();
    check(int'(slot_vld), 0, "R9 reset mid slots");
    check(int'(uop_total), 0, "R9 reset mid total");
    #1;
    check(int'(in_ready[0]), 1, "R9 reset mid ready");
    tick();
    check(int'(slot_vld), 0, "R9 after reset idle");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule